// File: doc/BRIEF.md
# Normalized Min-Sum Check-Node Reply Unit

This unit forms the reply that one parity row of a layered low-density parity-check decoder sends back to each of its participating edges. A row summary arrives with each transfer: the smallest and the second-smallest message magnitude seen in the row, the edge index that held the smallest, and the XOR of all message signs in the row. Every lane also supplies its own edge index and its own message sign. From these inputs, each lane forms a 1-bit sign plus magnitude reply, and all lanes work in parallel.

Each lane leaves its own contribution out of the reply. If the lane held the row minimum, it takes the second-smallest magnitude; every other lane takes the smallest. The chosen magnitude is attenuated to three quarters using a shift and a subtract, and is limited to a configurable ceiling. The sign comes from the parity of the other edges. A single register between the selection step and the scaling step gives a fixed latency of one clock. A valid flag travels alongside the data through that register.

Top module: `nms_reply_unit`

## Requirements
- R1: A lane whose edge index equals the row's minimum index takes the second-smallest magnitude. Every other lane takes the smallest magnitude. When several lanes carry the matching index, each of them takes the second-smallest.
- R2: The chosen magnitude m is scaled to m - floor(m/4), computed as a right shift by two and a subtraction, with no multiplier.
- R3: The scaled magnitude is limited to the parameter CLAMP_MAX before the sign is attached.
- R4: The reply sign is the row parity XOR the lane's own input sign. Lane i occupies bits [i*(MAG_W+1) +: MAG_W+1] of the reply bus. Within that field the top bit is the sign (1 means negative) and the low MAG_W bits are the magnitude.
- R5: A reply whose magnitude is zero is always driven with sign 0, whatever the parities are.
- R6: The reply for inputs presented at clock edge k appears after edge k, one cycle later. The output valid flag equals the input valid flag of the previous cycle.
- R7: While reset (active low, asynchronous) is held, the output valid flag is 0 and every reply field is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Row summary and lane inputs are valid |
| min1_i | input | MAG_W | Smallest magnitude in the row |
| min2_i | input | MAG_W | Second-smallest magnitude in the row |
| min_idx_i | input | IDX_W | Edge index that held the smallest magnitude |
| parity_i | input | 1 | XOR of all message signs in the row |
| edge_idx_i | input | LANES*IDX_W | Per-lane edge index, lane i at [i*IDX_W +: IDX_W] |
| edge_sgn_i | input | LANES | Per-lane own message sign |
| out_valid_o | output | 1 | Reply bus carries a valid row |
| reply_o | output | LANES*(MAG_W+1) | Per-lane sign-magnitude reply |

## Verification
The bench builds the unit with 4 lanes, 6-bit magnitudes, 3-bit indices and CLAMP_MAX set to 20. With that ceiling, the three-quarter scaling of ordinary 6-bit magnitudes can exceed the limit. The default ceiling of 63 can never be reached, so this setting is what lets the bench test the clamp. The 3-bit index field can hold a minimum index that no lane carries, and it can also hold an index that every lane shares. The bench streams rows back to back, so each reply has to line up with the row that produced it exactly one cycle earlier.

// File: rtl/nms_pkg.sv
package nms_pkg;
    localparam int unsigned NMS_LANES_DEF = 128;
    localparam int unsigned NMS_MAG_W_DEF = 6;
    localparam int unsigned NMS_IDX_W_DEF = 7;

    typedef enum logic {
        PICK_LOWEST = 1'b0,
        PICK_RUNNER = 1'b1
    } pick_e;
endpackage

// File: rtl/nms_lane_select.sv
module nms_lane_select
    import nms_pkg::*;
#(
    parameter int unsigned MAG_W = NMS_MAG_W_DEF,
    parameter int unsigned IDX_W = NMS_IDX_W_DEF
) (
    input  logic [MAG_W-1:0] lowest_i,
    input  logic [MAG_W-1:0] runner_i,
    input  logic [IDX_W-1:0] low_idx_i,
    input  logic             parity_i,
    input  logic [IDX_W-1:0] own_idx_i,
    input  logic             own_sgn_i,
    output logic [MAG_W-1:0] mag_o,
    output logic             sgn_o
);
    pick_e pick;

    always_comb begin
        pick  = (own_idx_i == low_idx_i) ? PICK_RUNNER : PICK_LOWEST;
        mag_o = (pick == PICK_RUNNER) ? runner_i : lowest_i;
        sgn_o = parity_i ^ own_sgn_i;
    end
endmodule

// File: rtl/nms_lane_scale.sv
module nms_lane_scale
    import nms_pkg::*;
#(
    parameter int unsigned MAG_W     = NMS_MAG_W_DEF,
    parameter int unsigned CLAMP_MAX = (1 << MAG_W) - 1
) (
    input  logic [MAG_W-1:0] mag_i,
    input  logic             sgn_i,
    output logic [MAG_W:0]   reply_o
);
    localparam logic [MAG_W-1:0] CLAMP_V = MAG_W'(CLAMP_MAX);

    logic [MAG_W-1:0] quarter;
    logic [MAG_W-1:0] scaled;
    logic [MAG_W-1:0] limited;

    always_comb begin
        quarter = mag_i >> 2;
        scaled  = mag_i - quarter;
        limited = (scaled > CLAMP_V) ? CLAMP_V : scaled;
        reply_o = {sgn_i & (limited != '0), limited};
    end
endmodule

// File: rtl/nms_reply_unit.sv
module nms_reply_unit
    import nms_pkg::*;
#(
    parameter int unsigned LANES     = NMS_LANES_DEF,
    parameter int unsigned MAG_W     = NMS_MAG_W_DEF,
    parameter int unsigned IDX_W     = NMS_IDX_W_DEF,
    parameter int unsigned CLAMP_MAX = (1 << MAG_W) - 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid_i,
    input  logic [MAG_W-1:0]           min1_i,
    input  logic [MAG_W-1:0]           min2_i,
    input  logic [IDX_W-1:0]           min_idx_i,
    input  logic                       parity_i,
    input  logic [LANES*IDX_W-1:0]     edge_idx_i,
    input  logic [LANES-1:0]           edge_sgn_i,
    output logic                       out_valid_o,
    output logic [LANES*(MAG_W+1)-1:0] reply_o
);
    localparam int unsigned REPLY_W = MAG_W + 1;
    localparam logic [MAG_W-1:0] CLAMP_V = MAG_W'(CLAMP_MAX);

    typedef struct packed {
        logic                        vld;
        logic [LANES-1:0][MAG_W-1:0] mag;
        logic [LANES-1:0]            sgn;
    } mid_t;

    mid_t mid_d, mid_q;

    logic [LANES-1:0][MAG_W-1:0]   sel_mag;
    logic [LANES-1:0]              sel_sgn;
    logic [LANES-1:0][REPLY_W-1:0] lane_reply;

    for (genvar i = 0; i < LANES; i++) begin : g_sel
        nms_lane_select #(.MAG_W(MAG_W), .IDX_W(IDX_W)) u_sel (
            .lowest_i  (min1_i),
            .runner_i  (min2_i),
            .low_idx_i (min_idx_i),
            .parity_i  (parity_i),
            .own_idx_i (edge_idx_i[i*IDX_W +: IDX_W]),
            .own_sgn_i (edge_sgn_i[i]),
            .mag_o     (sel_mag[i]),
            .sgn_o     (sel_sgn[i])
        );
    end

    always_comb begin
        mid_d     = mid_q;
        mid_d.vld = in_valid_i;
        mid_d.mag = sel_mag;
        mid_d.sgn = sel_sgn;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mid_q <= '0;
        else        mid_q <= mid_d;
    end

    for (genvar i = 0; i < LANES; i++) begin : g_scale
        nms_lane_scale #(.MAG_W(MAG_W), .CLAMP_MAX(CLAMP_MAX)) u_scale (
            .mag_i   (mid_q.mag[i]),
            .sgn_i   (mid_q.sgn[i]),
            .reply_o (lane_reply[i])
        );
        assign reply_o[i*REPLY_W +: REPLY_W] = lane_reply[i];

        p_pick_runner_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid_i && edge_idx_i[i*IDX_W +: IDX_W] == min_idx_i)
            |=> mid_q.mag[i] == $past(min2_i));
        p_pick_lowest_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid_i && edge_idx_i[i*IDX_W +: IDX_W] != min_idx_i)
            |=> mid_q.mag[i] == $past(min1_i));
        p_scale_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
            lane_reply[i][MAG_W-1:0] <= mid_q.mag[i]);
        p_ceiling_r3: assert property (@(posedge clk) disable iff (!rst_n)
            lane_reply[i][MAG_W-1:0] <= CLAMP_V);
        p_sign_r4: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid_i |=> mid_q.sgn[i] == $past(parity_i ^ edge_sgn_i[i]));
        p_zero_pos_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (lane_reply[i][MAG_W-1:0] == '0) |-> !lane_reply[i][MAG_W]);
    end

    assign out_valid_o = mid_q.vld;

    p_valid_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i |=> out_valid_o);
    p_valid_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid_i |=> !out_valid_o);
endmodule

// File: tb/nms_reply_unit_bench.sv
module nms_reply_unit_bench;
    localparam int L  = 4;
    localparam int MW = 6;
    localparam int IW = 3;
    localparam int CM = 20;
    localparam int RW = MW + 1;

    typedef struct packed {
        logic [MW-1:0]   lo;
        logic [MW-1:0]   ru;
        logic [IW-1:0]   midx;
        logic            par;
        logic [L*IW-1:0] eidx;
        logic [L-1:0]    sgn;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VEC [NV] = '{
        '{6'd8,  6'd12, 3'd1, 1'b0, 12'h688, 4'b0000},
        '{6'd0,  6'd5,  3'd0, 1'b1, 12'h688, 4'b0000},
        '{6'd40, 6'd63, 3'd3, 1'b1, 12'h688, 4'b1010},
        '{6'd3,  6'd3,  3'd7, 1'b0, 12'h688, 4'b1111},
        '{6'd1,  6'd2,  3'd2, 1'b1, 12'h688, 4'b0110},
        '{6'd26, 6'd27, 3'd0, 1'b0, 12'h688, 4'b0101},
        '{6'd9,  6'd17, 3'd2, 1'b1, 12'h492, 4'b1001}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [MW-1:0]   min1 = '0, min2 = '0;
    logic [IW-1:0]   midx = '0;
    logic            par = 1'b0;
    logic [L*IW-1:0] eidx = '0;
    logic [L-1:0]    esgn = '0;
    logic            out_valid;
    logic [L*RW-1:0] reply;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    nms_reply_unit #(.LANES(L), .MAG_W(MW), .IDX_W(IW), .CLAMP_MAX(CM)) u_nms_reply_unit (
        .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid),
        .min1_i(min1), .min2_i(min2), .min_idx_i(midx), .parity_i(par),
        .edge_idx_i(eidx), .edge_sgn_i(esgn),
        .out_valid_o(out_valid), .reply_o(reply)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int model_mag(input vec_t v, input int i);
        int m;
        m = (v.eidx[i*IW +: IW] == v.midx) ? int'(v.ru) : int'(v.lo);
        m = m - m / 4;
        if (m > CM) m = CM;
        return m;
    endfunction

    function automatic int model_sgn(input vec_t v, input int i);
        if (model_mag(v, i) == 0) return 0;
        return int'(v.par ^ v.sgn[i]);
    endfunction

    task automatic drive(input vec_t v, input logic vld);
        in_valid = vld;
        min1 = v.lo; min2 = v.ru; midx = v.midx; par = v.par;
        eidx = v.eidx; esgn = v.sgn;
    endtask

    task automatic check_vec(input vec_t v);
        check("R6 valid", int'(out_valid), 1);
        for (int i = 0; i < L; i++) begin
            check("R1/R2/R3 magnitude", int'(reply[i*RW +: MW]), model_mag(v, i));
            check("R4/R5 sign", int'(reply[i*RW + MW]), model_sgn(v, i));
        end
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        vec_t v;
        repeat (3) @(negedge clk);
        // R7: reset state
        check("R7 valid in reset", int'(out_valid), 0);
        check("R7 reply in reset", int'(reply), 0);
        rst_n = 1'b1;

        // Streamed table: each row checked one cycle after it is driven (R6)
        @(negedge clk);
        drive(VEC[0], 1'b1);
        for (int k = 1; k < NV; k++) begin
            @(negedge clk);
            check_vec(VEC[k-1]);
            drive(VEC[k], 1'b1);
        end
        @(negedge clk);
        check_vec(VEC[NV-1]);
        drive(VEC[0], 1'b0);
        @(negedge clk);
        check("R6 valid drops", int'(out_valid), 0);

        // R1: lane 2 matches the min index -> 17 -> 13; others 9 -> 7
        v = '{6'd9, 6'd17, 3'd2, 1'b0, 12'h688, 4'b0000};
        drive(v, 1'b1);
        @(negedge clk);
        check("R1 runner lane", int'(reply[2*RW +: MW]), 13);
        check("R1 lowest lane", int'(reply[0*RW +: MW]), 7);

        // R3: 63 -> 48 limited to 20, sign negative on lane 0
        v = '{6'd63, 6'd63, 3'd7, 1'b1, 12'h688, 4'b0000};
        drive(v, 1'b1);
        @(negedge clk);
        check("R3 ceiling", int'(reply[0*RW +: MW]), CM);
        check("R4 sign negative", int'(reply[MW]), 1);

        // R5: zero magnitude with odd parity stays positive
        v = '{6'd0, 6'd0, 3'd0, 1'b1, 12'h688, 4'b0000};
        drive(v, 1'b1);
        @(negedge clk);
        check("R5 zero positive", int'(reply[1*RW +: RW]), 0);

        // R7: mid-run reset clears state
        v = '{6'd30, 6'd40, 3'd1, 1'b1, 12'h688, 4'b0000};
        drive(v, 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R7 valid after reset", int'(out_valid), 0);
        check("R7 reply after reset", int'(reply), 0);
        @(negedge clk);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule